// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the bus-facing engine of a 256-byte serial memory. It runs on a fast system clock. It oversamples the open-drain clock and data lines, recognises bus conditions and decodes the device header. It then plays the slave role for writes and reads. Write bytes are not stored here. Each one is offered to a separate commit stage with its target address. A STOP then tells that stage to apply the bytes it holds, and a START that arrives first tells it to drop them.

Reads take bytes from a combinational memory read port. The port is addressed by an internal pointer that all commands share. The data line is driven only as a pull-down enable, so the pad and the pull-up stay outside the block. A one-bit strap selects which of two possible device identities the engine answers to.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A START is data falling while clock is high, and a STOP is data rising while clock is high. Clock pulses before the first START are ignored and never cause the data line to be driven. A STOP releases the data line.
- R2: The header byte is sent MSB first. Its top four bits are 1010, the next bit must equal `dev_sel`, the next two bits are 0, and the last bit selects read (1) or write (0). On any other header the block goes idle and does not drive the line.
- R3: The block pulls data low during the ninth clock to acknowledge a matching header, the word-address byte and every write data byte.
- R4: Incoming bits are taken on the clock's rising edge. The pull-down enable changes only while the clock is low.
- R5: Each write data byte appears on `wr_stb` with `wr_addr` and `wr_data`. After each byte, the three low address bits step by one and wrap inside their 8-byte page, while the upper bits hold.
- R6: A STOP that follows at least one write data byte pulses `wr_commit`. A START that comes before that STOP pulses `wr_abort` instead and gives no commit.
- R7: A random read works as follows: a write header and a word address, then a repeated START and a read header. It returns the byte at that address, MSB first.
- R8: A current read starts at the last read address plus one. After a write it starts at the last address written.
- R9: While the master acknowledges low, the block keeps sending consecutive bytes, and the address wraps from 0xFF to 0x00.
- R10: A high acknowledge from the master ends the read. The line then stays released until the next START or STOP.
- R11: A START in the middle of any byte drops the partial byte and begins a fresh header.
- R12: While `commit_busy` is high, the block does not acknowledge a header.
- R13: Out of reset, `sda_oe` is low, no strobe is active, and the read pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line sample |
| sda_i | input | 1 | Bus data line sample |
| sda_oe | output | 1 | Pull data line low when 1 |
| dev_sel | input | 1 | Identity strap compared with header bit 3 |
| commit_busy | input | 1 | Commit stage is still writing |
| mem_addr | output | ADDR_W | Read port address (shared pointer) |
| mem_rdata | input | 8 | Read port data for `mem_addr` |
| wr_stb | output | 1 | One-cycle strobe: a write byte is offered |
| wr_addr | output | ADDR_W | Address of the offered byte |
| wr_data | output | 8 | Offered byte |
| wr_commit | output | 1 | One-cycle pulse: apply the offered bytes |
| wr_abort | output | 1 | One-cycle pulse: discard the offered bytes |

## Verification
Single-byte writes are mixed with random and current reads in an order that makes the pointer rule observable. A current read after a read gives a different byte than a current read after a write to the same place. A page write that starts two bytes below a page boundary checks that the third byte lands at the page base and not in the next page. Sequential reads across 0xFF test the wrap. Clocking on after a master NACK, over a byte of zeros, tests that transmission has really stopped. Mismatched headers, clock pulses before any START, a START inside a byte, a write cut short by a repeated START, and a header sent while the commit stage is busy each test a path that must leave the line released or the memory unchanged.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_HACK,
        ST_WADDR,
        ST_AACK,
        ST_WDATA,
        ST_DACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } twi_state_e;

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [VOTE_TAPS-1:0]   win;
        logic                   out;
    } filt_t;

    filt_t f_d, f_q;

    function automatic logic majority(input logic [VOTE_TAPS-1:0] w);
        int ones;
        ones = 0;
        for (int i = 0; i < VOTE_TAPS; i++) ones += int'(w[i]);
        return ones > (VOTE_TAPS / 2);
    endfunction

    always_comb begin
        f_d      = f_q;
        f_d.sync = {f_q.sync[SYNC_STAGES-2:0], line_i};
        f_d.win  = {f_q.win[VOTE_TAPS-2:0], f_q.sync[SYNC_STAGES-1]};
        f_d.out  = majority(f_q.win);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '1;
        else        f_q <= f_d;
    end

    assign line_o = f_q.out;

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t p_d, p_q;

    always_comb begin
        p_d.scl = scl_f;
        p_d.sda = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '1;
        else        p_q <= p_d;
    end

    assign ev_start = scl_f & p_q.scl & p_q.sda & ~sda_f;
    assign ev_stop  = scl_f & p_q.scl & ~p_q.sda & sda_f;
    assign ev_rise  = scl_f & ~p_q.scl;
    assign ev_fall  = ~scl_f & p_q.scl;

endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_val,
    input  logic              wr_adv,
    input  logic              rd_adv,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] wr_ptr
);

    typedef struct packed {
        logic [ADDR_W-1:0] rd;
        logic [ADDR_W-1:0] wr;
    } ptr_t;

    ptr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (set_en) begin
            c_d.rd = set_val;
            c_d.wr = set_val;
        end else if (wr_adv) begin
            c_d.rd = c_q.wr;
            c_d.wr = {c_q.wr[ADDR_W-1:PAGE_W], c_q.wr[PAGE_W-1:0] + PAGE_W'(1)};
        end else if (rd_adv) begin
            c_d.rd = c_q.rd + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_ptr = c_q.rd;
    assign wr_ptr = c_q.wr;

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    input  logic                dev_sel,
    input  logic                commit_busy,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic                wr_stb,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                wr_commit,
    output logic                wr_abort
);

    localparam int NLINES = 2;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    typedef struct packed {
        twi_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic                oe;
        logic                mack;
        logic                pend;
        logic                stb;
        logic                commit;
        logic                abort;
        logic [ADDR_W-1:0]   waddr;
        logic [BYTE_W-1:0]   wdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic scl_f, sda_f;
    logic ev_start, ev_stop, ev_rise, ev_fall;
    logic set_en, wr_adv, rd_adv;
    logic [ADDR_W-1:0] rd_ptr, wr_ptr;
    logic byte_done, hdr_match;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        twi_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .VOTE_TAPS  (VOTE_TAPS)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    twi_bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall)
    );

    twi_addr_ctr #(
        .ADDR_W(ADDR_W),
        .PAGE_W(PAGE_W)
    ) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (set_en),
        .set_val(r_q.sh[ADDR_W-1:0]),
        .wr_adv (wr_adv),
        .rd_adv (rd_adv),
        .rd_ptr (rd_ptr),
        .wr_ptr (wr_ptr)
    );

    assign byte_done = ev_fall && (r_q.cnt == FULL);
    assign hdr_match = (r_q.sh[7:4] == DEV_TYPE) && (r_q.sh[3] == dev_sel)
                       && (r_q.sh[2:1] == 2'b00);

    always_comb begin
        r_d        = r_q;
        r_d.stb    = 1'b0;
        r_d.commit = 1'b0;
        r_d.abort  = 1'b0;
        set_en     = 1'b0;
        wr_adv     = 1'b0;
        rd_adv     = 1'b0;

        if (ev_start) begin
            r_d.st  = ST_HDR;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
            if (r_q.pend) begin
                r_d.abort = 1'b1;
                r_d.pend  = 1'b0;
            end
        end else if (ev_stop) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
            if (r_q.pend) begin
                r_d.commit = 1'b1;
                r_d.pend   = 1'b0;
            end
        end else begin
            if ((r_q.st == ST_HDR || r_q.st == ST_WADDR || r_q.st == ST_WDATA)
                && ev_rise && (r_q.cnt < FULL)) begin
                r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_f};
                r_d.cnt = r_q.cnt + CNT_W'(1);
            end

            unique case (r_q.st)
                ST_HDR: if (byte_done) begin
                    if (hdr_match && !commit_busy) begin
                        r_d.st = ST_HACK;
                        r_d.oe = 1'b1;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
                ST_HACK: if (ev_fall) begin
                    r_d.cnt = '0;
                    if (r_q.sh[0]) begin
                        r_d.sh   = mem_rdata;
                        r_d.oe   = ~mem_rdata[BYTE_W-1];
                        r_d.mack = 1'b1;
                        rd_adv   = 1'b1;
                        r_d.st   = ST_RDATA;
                    end else begin
                        r_d.oe = 1'b0;
                        r_d.st = ST_WADDR;
                    end
                end
                ST_WADDR: if (byte_done) begin
                    set_en = 1'b1;
                    r_d.oe = 1'b1;
                    r_d.st = ST_AACK;
                end
                ST_AACK, ST_DACK: if (ev_fall) begin
                    r_d.oe  = 1'b0;
                    r_d.cnt = '0;
                    r_d.st  = ST_WDATA;
                end
                ST_WDATA: if (byte_done) begin
                    r_d.stb   = 1'b1;
                    r_d.waddr = wr_ptr;
                    r_d.wdata = r_q.sh;
                    wr_adv    = 1'b1;
                    r_d.pend  = 1'b1;
                    r_d.oe    = 1'b1;
                    r_d.st    = ST_DACK;
                end
                ST_RDATA: if (ev_fall) begin
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.oe = 1'b0;
                        r_d.st = ST_RACK;
                    end else begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], 1'b0};
                        r_d.oe  = ~r_q.sh[BYTE_W-2];
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
                ST_RACK: begin
                    if (ev_rise) r_d.mack = sda_f;
                    if (ev_fall) begin
                        r_d.cnt = '0;
                        if (!r_q.mack) begin
                            r_d.sh   = mem_rdata;
                            r_d.oe   = ~mem_rdata[BYTE_W-1];
                            r_d.mack = 1'b1;
                            rd_adv   = 1'b1;
                            r_d.st   = ST_RDATA;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.mack <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe    = r_q.oe;
    assign mem_addr  = rd_ptr;
    assign wr_stb    = r_q.stb;
    assign wr_addr   = r_q.waddr;
    assign wr_data   = r_q.wdata;
    assign wr_commit = r_q.commit;
    assign wr_abort  = r_q.abort;

endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              wr_stb,
    input logic              wr_commit,
    input logic              wr_abort,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] mem_addr
);

    // R4
    oe_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R6
    wr_events_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, wr_commit, wr_abort}));

    // R8
    ptr_tracks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (mem_addr == wr_addr));

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !sda_oe);

    // R6
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .wr_commit(wr_commit),
    .wr_abort (wr_abort),
    .wr_addr  (wr_addr),
    .mem_addr (mem_addr)
);

// File: tb/sim_twi_eeprom_slave.sv
module sim_twi_eeprom_slave;

    localparam int Q         = 10;
    localparam int BUSY_CYC  = 600;
    localparam logic [7:0] HDR_W = 8'hA8;  // 1010, dev_sel=1, 00, write
    localparam logic [7:0] HDR_R = 8'hA9;
    localparam logic [7:0] HDR_X = 8'hA0;  // identity bit 0: mismatch

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic sda_oe, sda_bus;
    logic commit_busy;
    logic [7:0] mem_addr, mem_rdata, wr_addr, wr_data;
    logic wr_stb, wr_commit, wr_abort;

    int nchk = 0;
    int nfail = 0;
    int oe_hits = 0;
    int n_abort = 0;
    int n_commit = 0;

    logic [7:0] mem [256];
    logic [7:0] pa [16];
    logic [7:0] pd [16];
    int pn;
    int busy_cnt;

    always #10 clk = ~clk;

    assign sda_bus     = msda & ~sda_oe;
    assign mem_rdata   = mem[mem_addr];
    assign commit_busy = (busy_cnt != 0);

    twi_eeprom_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_oe     (sda_oe),
        .dev_sel    (1'b1),
        .commit_busy(commit_busy),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_commit  (wr_commit),
        .wr_abort   (wr_abort)
    );

    // commit-stage model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
            pn <= 0;
            busy_cnt <= 0;
        end else begin
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if (wr_stb && pn < 16) begin
                pa[pn] <= wr_addr;
                pd[pn] <= wr_data;
                pn <= pn + 1;
            end
            if (wr_commit) begin
                for (int i = 0; i < 16; i++) if (i < pn) mem[pa[i]] <= pd[i];
                pn <= 0;
                busy_cnt <= BUSY_CYC;
            end
            if (wr_abort) pn <= 0;
        end
    end

    always @(posedge clk) begin
        if (sda_oe) oe_hits <= oe_hits + 1;
        if (wr_abort) n_abort <= n_abort + 1;
        if (wr_commit) n_commit <= n_commit + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b1; wq();
        scl = 1'b1;  wq();
        msda = 1'b0; wq();
        scl = 1'b0;  wq();
    endtask

    task automatic bus_stop();
        msda = 1'b0; wq();
        scl = 1'b1;  wq();
        msda = 1'b1; wq();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        msda = b; wq();
        scl = 1'b1; wq();
        s = sda_bus;
        scl = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic get_byte(input logic ack_low, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~ack_low, s);
    endtask

    task automatic wait_ready();
        while (commit_busy) @(negedge clk);
        wq();
    endtask

    task automatic do_write(input logic [7:0] a, input logic [23:0] dv, input int n);
        logic ack;
        bus_start();
        put_byte(HDR_W, ack); chk("R3 header ack", ack, 1);
        put_byte(a, ack);     chk("R3 word address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            put_byte(dv[8*i +: 8], ack); chk("R3 data ack", ack, 1);
        end
        bus_stop();
        wait_ready();
    endtask

    task automatic rand_hdr(input logic [7:0] a);
        logic ack;
        bus_start();
        put_byte(HDR_W, ack); chk("R7 write header ack", ack, 1);
        put_byte(a, ack);     chk("R7 address ack", ack, 1);
        bus_start();
        put_byte(HDR_R, ack); chk("R7 read header ack", ack, 1);
    endtask

    task automatic cur_hdr();
        logic ack;
        bus_start();
        put_byte(HDR_R, ack); chk("R8 current read header ack", ack, 1);
    endtask

    // op[17:16]: 0 write, 1 random read, 2 current read; addr[15:8]; data[7:0]
    localparam logic [17:0] VEC [12] = '{
        {2'd0, 8'h10, 8'hA5},
        {2'd0, 8'h11, 8'h3C},
        {2'd1, 8'h10, 8'hA5},
        {2'd2, 8'h11, 8'h3C},
        {2'd2, 8'h12, 8'hFF},
        {2'd0, 8'h20, 8'h77},
        {2'd2, 8'h20, 8'h77},
        {2'd1, 8'h11, 8'h3C},
        {2'd2, 8'h12, 8'hFF},
        {2'd0, 8'h12, 8'hC8},
        {2'd2, 8'h12, 8'hC8},
        {2'd2, 8'h13, 8'hFF}
    };

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic ack;
        logic s;
        logic [7:0] d;
        int snap, snap2, lows;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R13 reset state
        chk("R13 sda_oe after reset", sda_oe, 0);
        chk("R13 wr_stb after reset", wr_stb, 0);
        chk("R13 pointer after reset", mem_addr, 0);

        // R1: clocking a valid header with no START first
        snap = oe_hits;
        scl = 1'b0; wq();
        put_byte(HDR_W, ack);
        chk("R1 no ack before START", ack, 0);
        chk("R1 line never driven before START", oe_hits - snap, 0);

        // table walk: R7 random reads, R8 pointer rules
        for (int v = 0; v < 12; v++) begin
            case (VEC[v][17:16])
                2'd0: do_write(VEC[v][15:8], {16'h0, VEC[v][7:0]}, 1);
                2'd1: begin
                    rand_hdr(VEC[v][15:8]);
                    get_byte(1'b0 == 1'b1, d);
                    bus_stop();
                    chk("R7 random read data", d, VEC[v][7:0]);
                end
                default: begin
                    cur_hdr();
                    get_byte(1'b0, d);
                    bus_stop();
                    chk("R8 current read data", d, VEC[v][7:0]);
                end
            endcase
            wq();
        end

        // R2 header mismatch
        snap = oe_hits;
        bus_start();
        put_byte(HDR_X, ack);
        bus_stop();
        chk("R2 mismatch not acked", ack, 0);
        chk("R2 mismatch never drives", oe_hits - snap, 0);

        // R5 page wrap: 3E,3F then 38
        do_write(8'h3E, 24'h93_92_91, 3);
        rand_hdr(8'h38); get_byte(1'b0, d); bus_stop();
        chk("R5 page wrap to base", d, 8'h93);
        rand_hdr(8'h40); get_byte(1'b0, d); bus_stop();
        chk("R5 next page untouched", d, 8'hFF);
        rand_hdr(8'h3E); get_byte(1'b0, d); bus_stop();
        chk("R5 first page byte", d, 8'h91);
        cur_hdr(); get_byte(1'b0, d); bus_stop();
        chk("R8 current read after read", d, 8'h92);

        // R9 sequential wrap, R10 NACK
        do_write(8'hFE, 24'h00_22_11, 2);
        do_write(8'h00, 24'h00_00_33, 2);
        rand_hdr(8'hFE);
        get_byte(1'b1, d); chk("R9 sequential byte FE", d, 8'h11);
        get_byte(1'b1, d); chk("R9 sequential byte FF", d, 8'h22);
        get_byte(1'b0, d); chk("R9 wrap to 00", d, 8'h33);
        lows = 0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            if (!s) lows++;
        end
        chk("R10 line released after NACK", lows, 0);
        bus_stop();
        cur_hdr(); get_byte(1'b0, d); bus_stop();
        chk("R8 current read after wrap", d, 8'h00);

        // R6 write cut by repeated START
        snap = n_abort; snap2 = n_commit;
        bus_start();
        put_byte(HDR_W, ack);
        put_byte(8'h50, ack);
        put_byte(8'h99, ack);
        bus_start();
        put_byte(HDR_R, ack);
        get_byte(1'b0, d);
        bus_stop();
        chk("R6 uncommitted byte absent", d, 8'hFF);
        chk("R6 abort pulse", n_abort - snap, 1);
        chk("R6 no commit", n_commit - snap2, 0);
        snap2 = n_commit;
        do_write(8'h51, 24'h00_00_5D, 1);
        chk("R6 commit on STOP", n_commit - snap2, 1);

        // R11 START in mid byte
        bus_start();
        clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
        bus_start();
        put_byte(HDR_W, ack); chk("R11 header after mid-byte START", ack, 1);
        put_byte(8'h10, ack);
        bus_start();
        put_byte(HDR_R, ack);
        get_byte(1'b0, d);
        bus_stop();
        chk("R11 read after restart", d, 8'hA5);

        // R12 busy
        bus_start();
        put_byte(HDR_W, ack); put_byte(8'h60, ack); put_byte(8'h5A, ack);
        bus_stop();
        bus_start();
        put_byte(HDR_W, ack);
        bus_stop();
        chk("R12 no ack while busy", ack, 0);
        wait_ready();
        rand_hdr(8'h60); get_byte(1'b0, d); bus_stop();
        chk("R12 data after busy", d, 8'h5A);

        wq();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule